// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block lets software raise an inter-processor interrupt on any hart. Each hart has one 32-bit register in a small bus window, and one level interrupt output. A write with bit 0 set raises that hart's line. Other processors use it to wake a hart or to signal it.

A build-time mode parameter picks one of two variants. In machine mode the register can be read and written: bit 0 shows the pending state, and writing zero lowers the line. In supervisor mode the register can only set. It always reads as zero, and a bus write of zero does nothing. The line is lowered by a per-hart clear input, driven by the logic that services the interrupt. The bus is a simple single-cycle register port. Read data is registered and appears the cycle after the read request.

Top module: `swi_bank`

## Requirements
- R1: Hart i owns the register at byte offset 4*i. Any address whose word index is NUM_HARTS or more is unmapped: it reads zero and writes to it change no output.
- R2: An accepted write with wdata bit 0 equal to 1 raises hart_irq of the addressed hart only, at the clock edge that accepts the write. Wdata bits 31..1 are ignored.
- R3: In machine mode, an accepted write with bit 0 equal to 0 lowers the addressed hart's hart_irq at the accepting edge.
- R4: In supervisor mode, a write with bit 0 equal to 0 changes no output.
- R5: In machine mode, a legal read returns the hart's pending state in bit 0, with bits 31..1 zero. bus_rdata takes this value at the edge that accepts the read and holds it until the next read.
- R6: In supervisor mode, bus_rdata is zero for every read.
- R7: An access is legal only if bus_addr[1:0] is 0 and bus_be is 4'b1111. An illegal read returns zero, and an illegal write changes no output.
- R8: While reset is asserted, and after it is released, all hart_irq bits and bus_rdata are zero.
- R9: In supervisor mode, hart_clr[i] lowers hart_irq[i] at the next edge. A set write to the same hart in the same cycle wins, and the line stays high.
- R10: In machine mode, hart_clr has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| bus_valid | input | 1 | Access request, accepted on this edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the window |
| bus_be | input | 4 | Byte enables. All four must be set for a legal access. |
| bus_wdata | input | 32 | Write data. Only bit 0 is used. |
| bus_rdata | output | 32 | Registered read data |
| hart_clr | input | NUM_HARTS | Per-hart clear, used in supervisor mode only |
| hart_irq | output | NUM_HARTS | Per-hart software interrupt level |

## Verification
Every result is due one register stage after its stimulus. A hart_irq change and a bus_rdata update both appear at the edge that accepts the request or the clear, with no further pipeline. The bench drives each access on a falling edge and takes it away on the next falling edge. It then compares both interrupt vectors and both read-data ports against an arithmetic model, so each sample lands exactly one edge after the stimulus. A machine-mode instance and a supervisor-mode instance share the bus. This lets one sweep over every address and byte-enable pattern exercise both variants side by side.

// File: rtl/swi_pkg.sv
package swi_pkg;
  typedef enum logic {
    MODE_MACHINE    = 1'b0,
    MODE_SUPERVISOR = 1'b1
  } swi_mode_e;

  localparam int unsigned SWI_REG_BYTES = 4;
  localparam int unsigned SWI_DATA_W    = 32;
endpackage

// File: rtl/swi_rst_sync.sv
module swi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  output logic [NUM_HARTS-1:0] wr_hit,
  output logic [NUM_HARTS-1:0] rd_hit,
  output logic                 rd_any
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     word_idx;
  logic                 aligned;
  logic                 mapped;
  logic [NUM_HARTS-1:0] hit;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00) && (bus_be == 4'b1111);
  assign mapped   = (32'(word_idx) < 32'(NUM_HARTS));

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
    assign hit[h] = bus_valid && aligned && mapped && (word_idx == IDX_W'(h));
  end

  assign wr_hit = bus_write  ? hit : '0;
  assign rd_hit = !bus_write ? hit : '0;
  assign rd_any = bus_valid && !bus_write;

  // R1: at most one hart register selected per access
  assert_single_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R7: a misaligned or partial access selects no register
  assert_illegal_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00 || bus_be != 4'b1111) |-> (hit == '0));
endmodule

// File: rtl/swi_pend_cell.sv
module swi_pend_cell #(
  parameter swi_pkg::swi_mode_e MODE = swi_pkg::MODE_MACHINE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic ext_clr,
  output logic pend
);
  logic pend_en;
  logic pend_d;

  if (MODE == swi_pkg::MODE_MACHINE) begin : g_machine
    always_comb begin
      pend_en = wr_en;
      pend_d  = wr_bit;
    end

    // R3/R10: the line only falls after a bus write of zero
    assert_fall_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(wr_en && !wr_bit));
  end else begin : g_supervisor
    always_comb begin
      pend_en = (wr_en && wr_bit) || ext_clr;
      pend_d  = wr_en && wr_bit;
    end

    // R4/R9: the line only falls after the external clear
    assert_fall_by_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(ext_clr));

    // R9: a set in the same cycle as a clear wins
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bit && ext_clr) |=> pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_d;
  end

  // R2: the line only rises after a set write
  assert_rise_by_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(wr_en && wr_bit));
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned        NUM_HARTS = 4,
  parameter int unsigned        ADDR_W    = 12,
  parameter swi_pkg::swi_mode_e MODE      = swi_pkg::MODE_MACHINE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_HARTS-1:0] hart_clr,
  output logic [NUM_HARTS-1:0] hart_irq
);
  localparam int unsigned DW = swi_pkg::SWI_DATA_W;

  logic                 rst_sync_n;
  logic [NUM_HARTS-1:0] wr_hit;
  logic [NUM_HARTS-1:0] rd_hit;
  logic                 rd_any;
  logic [NUM_HARTS-1:0] pend;
  logic [DW-1:0]        rdata_d;
  logic                 rdata_en;

  swi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swi_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .rd_any    (rd_any)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_cell
    swi_pend_cell #(.MODE(MODE)) u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_hit[h]),
      .wr_bit  (bus_wdata[0]),
      .ext_clr (hart_clr[h]),
      .pend    (pend[h])
    );
  end

  assign hart_irq = pend;

  if (MODE == swi_pkg::MODE_MACHINE) begin : g_rd_machine
    always_comb begin
      rdata_d = '0;
      rdata_d[0] = |(rd_hit & pend);
    end
  end else begin : g_rd_supervisor
    always_comb rdata_d = '0;
  end

  assign rdata_en = rd_any;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   bus_rdata <= '0;
    else if (rdata_en) bus_rdata <= rdata_d;
  end

  // R5: only bit 0 of the read data can ever be set
  assert_rdata_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DW-1:1] == '0);

  // R6: supervisor variant never returns a nonzero read
  assert_sup_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (MODE == swi_pkg::MODE_SUPERVISOR) |-> (bus_rdata == '0));

  // R7: an access that writes nothing leaves the lines unchanged unless a clear acts
  assert_no_write_stable_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_hit == '0 && hart_clr == '0) |=> $stable(hart_irq));
endmodule

// File: tb/swi_bank_test.sv
module swi_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata;
  logic [NH-1:0] clr_m, clr_s;
  logic [31:0]   rdata_m, rdata_s;
  logic [NH-1:0] irq_m, irq_s;

  logic [NH-1:0] exp_m, exp_s;
  logic [31:0]   exp_rdm, exp_rds;
  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swi_pkg::MODE_MACHINE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_m), .hart_clr(clr_m), .hart_irq(irq_m));

  swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swi_pkg::MODE_SUPERVISOR)) uut_sup (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_s), .hart_clr(clr_s), .hart_irq(irq_s));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "machine irq", 32'(irq_m), 32'(exp_m));
    check(tag, "supervisor irq", 32'(irq_s), 32'(exp_s));
    check(tag, "machine rdata", rdata_m, exp_rdm);
    check(tag, "supervisor rdata", rdata_s, exp_rds);
  endtask

  // One bus cycle; clear inputs apply in the same cycle. Checked one edge later.
  task automatic step(logic v, logic w, logic [AW-1:0] a, logic [3:0] be,
                      logic [31:0] wd, logic [NH-1:0] cm, logic [NH-1:0] cs, string tag);
    logic legal;
    int   idx;
    logic [NH-1:0] setm;
    logic [NH-1:0] clrm;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_be = be; bus_wdata = wd;
    clr_m = cm; clr_s = cs;
    idx   = int'(a) / 4;
    legal = v && (a[1:0] == 2'b00) && (be == 4'hF) && (idx < NH);
    setm = '0; clrm = '0;
    if (legal && w) begin
      if (wd[0]) setm[idx] = 1'b1;
      else       clrm[idx] = 1'b1;
    end
    if (v && !w) begin
      exp_rdm = (legal) ? {31'b0, exp_m[idx]} : 32'h0;
      exp_rds = 32'h0;
    end
    exp_m = (exp_m & ~clrm) | setm;
    exp_s = (exp_s & ~cs) | setm;
    @(negedge clk);
    bus_valid = 1'b0; clr_m = '0; clr_s = '0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD * 2);
    exp_m = '0; exp_s = '0; exp_rdm = '0; exp_rds = '0;
    check_all("R8");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R8");
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_be = 4'h0; bus_wdata = '0; clr_m = '0; clr_s = '0;
    exp_m = '0; exp_s = '0; exp_rdm = '0; exp_rds = '0;
    do_reset();

    // Address sweep: set, read, clear, read at every address (R1, R2, R3, R4, R5, R6, R7)
    for (int a = 0; a < 256; a++) begin
      string tw, tc;
      if (a % 4 != 0)         begin tw = "R7"; tc = "R7"; end
      else if (a / 4 >= NH)   begin tw = "R1"; tc = "R1"; end
      else                    begin tw = "R2"; tc = "R3"; end
      step(1'b1, 1'b1, AW'(a), 4'hF, 32'hFFFF_FFFF ^ 32'(a << 8), '0, '0, tw);
      step(1'b1, 1'b0, AW'(a), 4'hF, 32'h0, '0, '0, (tw == "R2") ? "R5" : tw);
      step(1'b1, 1'b1, AW'(a), 4'hF, 32'hFFFF_FFFE, '0, '0, (tc == "R3") ? "R4" : tc);
      step(1'b1, 1'b0, AW'(a), 4'hF, 32'h0, '0, '0, (tc == "R3") ? "R6" : tc);
    end

    // Partial byte enables are ignored (R7)
    for (int be = 0; be < 15; be++) begin
      step(1'b1, 1'b1, AW'(4), 4'(be), 32'h1, '0, '0, "R7");
      step(1'b1, 1'b0, AW'(4), 4'(be), 32'h0, '0, '0, "R7");
    end

    // Set every hart, read each back (R2, R5)
    for (int h = 0; h < NH; h++) step(1'b1, 1'b1, AW'(h * 4), 4'hF, 32'h3, '0, '0, "R2");
    for (int h = 0; h < NH; h++) step(1'b1, 1'b0, AW'(h * 4), 4'hF, 32'h0, '0, '0, "R5");

    // Clear inputs: supervisor honours them, machine ignores them (R9, R10)
    step(1'b0, 1'b0, '0, 4'h0, 32'h0, 4'b0100, 4'b0100, "R9");
    step(1'b0, 1'b0, '0, 4'h0, 32'h0, 4'b1111, 4'b0000, "R10");
    // Set and clear on the same hart in one cycle: set wins (R9)
    step(1'b1, 1'b1, AW'(4), 4'hF, 32'h1, 4'b0000, 4'b0011, "R9");
    step(1'b1, 1'b1, AW'(8), 4'hF, 32'h1, 4'b0000, 4'b0000, "R2");
    // Supervisor zero write ignored, machine zero write clears (R4, R3)
    step(1'b1, 1'b1, AW'(8), 4'hF, 32'h0, 4'b0000, 4'b0000, "R4");
    step(1'b1, 1'b0, AW'(12), 4'hF, 32'h0, 4'b0000, 4'b0000, "R6");

    // Reset in the middle of activity (R8)
    do_reset();
    step(1'b1, 1'b0, AW'(0), 4'hF, 32'h0, '0, '0, "R8");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule